// File: doc/BRIEF.md
# Odd-Byte Word Packer for a 16-bit Send Path

This block sits between a byte stream coming from memory and a peripheral bus that is two bytes wide. It takes one transfer command at a time. Each command carries a byte count and a chained flag. The block then accepts that many bytes through a valid/ready handshake and pairs them into bus words. Within a word, the earlier byte goes to the low lane and the later byte to the high lane.

A transfer with an odd byte count leaves one byte over. If the transfer is not chained, that byte goes out alone, with only the low lane enabled. If the transfer is chained, the byte is kept in a holding register and the residue flag is raised. The next transfer, chained or not, then treats its first incoming byte as the high-order partner of the held byte and sends the two as one full word. A run of wide sends should therefore chain every transfer except the last, so that no lone byte appears in the middle of the run.

At the end of each transfer the block emits a one-cycle completion pulse. The pulse carries the number of bytes actually placed on the bus and the residue flag. The count of bytes placed on the bus can differ from the count taken from memory when a residue is carried in or out.

Top module: `odd_byte_packer`

## Requirements
- R1: A synchronous reset empties the holding register and clears the residue flag (`done_resid` low). After reset, `bus_valid` and `done` are low and `cmd_ready` is high.
- R2: The bytes of a transfer fill each bus word low lane first (bits 7:0), then high lane (bits 15:8). Full words carry `bus_lane_en` = 2'b11.
- R3: A chained transfer that ends on an unpaired byte places no word for that byte on the bus. It ends with the byte held and `done_resid` = 1.
- R4: A non-chained transfer that ends on an unpaired byte sends it as a final word with the byte in bits 7:0, zero in bits 15:8, and `bus_lane_en` = 2'b01.
- R5: When the residue flag is set at the start of a transfer, the first incoming byte is placed in bits 15:8. The held byte is placed in bits 7:0 of the same word.
- R6: `done` is high for exactly one cycle per command. `done_sent` then equals the byte count, plus 1 if a residue was held at the start, minus 1 if a residue is held at the end.
- R7: While `done` is high, `done_resid` shows whether a byte is held for the next transfer.
- R8: A command with a byte count of zero accepts no bytes and raises `done` in the cycle after the command is accepted, with `done_sent` = 0. It leaves the residue flag unchanged.
- R9: While `bus_valid` is high and `bus_ready` is low, `bus_data` and `bus_lane_en` stay unchanged. While `bus_valid` is high, `in_ready` is low.
- R10: A non-chained transfer with a nonzero count always ends with `done_resid` = 0.
- R11: `cmd_ready` is high only between transfers. It is low from command acceptance through the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Transfer command offered |
| cmd_ready | output | 1 | Block idle, command accepted when valid |
| cmd_count | input | CNT_W | Bytes to take from memory |
| cmd_chain | input | 1 | Transfer is chained to the next |
| in_valid | input | 1 | Memory byte offered |
| in_ready | output | 1 | Byte accepted when valid |
| in_data | input | BYTE_W | Memory byte |
| bus_valid | output | 1 | Bus word offered |
| bus_ready | input | 1 | Bus word taken when valid |
| bus_data | output | 2*BYTE_W | Bus word, low lane in low bits |
| bus_lane_en | output | 2 | Lane enables, bit 0 low lane |
| done | output | 1 | One-cycle end-of-transfer pulse |
| done_sent | output | CNT_W+1 | Bytes placed on the bus by the transfer |
| done_resid | output | 1 | Residue byte held |

## Verification
The bench builds the block with 8-bit bytes and a 4-bit count field. This keeps every count from 0 through 7, plus the maximum of 15, within a short run. All counts are swept against both chained settings and both starting residue states. Each combination runs under three bus-ready patterns, so stalls land on lone, merged and ordinary words alike. A reset taken while a residue is held confirms that the held byte is really discarded.

// File: rtl/wbp_pkg.sv
package wbp_pkg;
   localparam int unsigned LANES = 2;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } wbp_state_e;

   localparam logic [LANES-1:0] EN_BOTH = 2'b11;
   localparam logic [LANES-1:0] EN_LOW  = 2'b01;
endpackage

// File: rtl/wbp_ctrl.sv
module wbp_ctrl
   import wbp_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cmd_valid,
   input  logic [CNT_W-1:0] cmd_count,
   input  logic             cmd_chain,
   output logic             cmd_ready,
   input  logic             in_valid,
   output logic             in_ready,
   output logic             take,
   output logic             last,
   output logic             chain,
   input  logic             out_busy,
   input  logic             hold_v,
   input  logic [1:0]       sent_inc,
   output logic             done,
   output logic [CNT_W:0]   done_sent,
   output logic             done_resid
);
   localparam int unsigned SENT_W = CNT_W + 1;

   generate
      if (CNT_W < 1) begin : g_bad_cnt
         $error("wbp_ctrl: CNT_W must be at least 1");
      end
   endgenerate

   wbp_state_e         st_q;
   logic [CNT_W-1:0]   rem_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [SENT_W-1:0]  sent_q;
   logic               chain_q;
   logic               hs_q;

   always_comb begin
      cmd_ready  = (st_q == ST_IDLE);
      in_ready   = (st_q == ST_RUN) && (rem_q != '0) && !out_busy;
      take       = in_ready && in_valid;
      last       = (rem_q == CNT_W'(1));
      chain      = chain_q;
      done       = (st_q == ST_FIN);
      done_sent  = sent_q;
      done_resid = hold_v;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q    <= ST_IDLE;
         rem_q   <= '0;
         cnt_q   <= '0;
         sent_q  <= '0;
         chain_q <= 1'b0;
         hs_q    <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (cmd_valid) begin
                  cnt_q   <= cmd_count;
                  rem_q   <= cmd_count;
                  chain_q <= cmd_chain;
                  hs_q    <= hold_v;
                  sent_q  <= '0;
                  st_q    <= (cmd_count == '0) ? ST_FIN : ST_RUN;
               end
            end
            ST_RUN: begin
               if (take) begin
                  rem_q  <= rem_q - CNT_W'(1);
                  sent_q <= sent_q + SENT_W'(sent_inc);
               end
               if ((rem_q == '0) && !out_busy) st_q <= ST_FIN;
            end
            ST_FIN:  st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   logic resid_expect;
   always_comb begin
      if (cnt_q == '0) resid_expect = hs_q;
      else             resid_expect = chain_q ? (hs_q ^ cnt_q[0]) : 1'b0;
   end

   // R6
   sent_balance_chk: assert property (@(posedge clk) disable iff (rst)
      done |-> (done_sent == SENT_W'(cnt_q) + SENT_W'(hs_q) - SENT_W'(hold_v)));

   // R6
   done_single_chk: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   // R3
   resid_rule_chk: assert property (@(posedge clk) disable iff (rst)
      done |-> (hold_v == resid_expect));

   // R8
   zero_count_chk: assert property (@(posedge clk) disable iff (rst)
      (cmd_ready && cmd_valid && (cmd_count == '0)) |=> (done && (hold_v == $past(hold_v))));

   // R11
   cmd_idle_chk: assert property (@(posedge clk) disable iff (rst)
      (cmd_ready && cmd_valid) |=> !cmd_ready);
endmodule

// File: rtl/wbp_pack.sv
module wbp_pack
   import wbp_pkg::*;
#(
   parameter int unsigned BYTE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    take,
   input  logic                    last,
   input  logic                    chain,
   input  logic [BYTE_W-1:0]       in_data,
   input  logic                    bus_ready,
   output logic                    hold_v,
   output logic                    out_busy,
   output logic [1:0]              sent_inc,
   output logic                    bus_valid,
   output logic [LANES*BYTE_W-1:0] bus_data,
   output logic [LANES-1:0]        bus_lane_en
);
   localparam int unsigned WORD_W = LANES * BYTE_W;

   logic [BYTE_W-1:0] hold_q;
   logic              hold_vq;
   logic              out_vq;
   logic [WORD_W-1:0] out_dq;
   logic [LANES-1:0]  out_eq;

   logic              lone;
   logic              emit;
   logic [WORD_W-1:0] nxt_word;
   logic [LANES-1:0]  nxt_en;
   logic [BYTE_W-1:0] lane_src [LANES];

   always_comb begin
      lone        = last && !chain && !hold_vq;
      emit        = take && (hold_vq || lone);
      lane_src[0] = hold_vq ? hold_q : in_data;
      lane_src[1] = hold_vq ? in_data : '0;
      nxt_en      = hold_vq ? EN_BOTH : EN_LOW;
      if (!take)        sent_inc = 2'd0;
      else if (hold_vq) sent_inc = 2'd2;
      else if (lone)    sent_inc = 2'd1;
      else              sent_inc = 2'd0;
   end

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         assign nxt_word[g*BYTE_W +: BYTE_W] = lane_src[g];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         hold_q  <= '0;
         hold_vq <= 1'b0;
         out_vq  <= 1'b0;
         out_dq  <= '0;
         out_eq  <= '0;
      end else begin
         if (out_vq && bus_ready) out_vq <= 1'b0;
         if (emit) begin
            out_vq <= 1'b1;
            out_dq <= nxt_word;
            out_eq <= nxt_en;
         end
         if (take) begin
            if (hold_vq) begin
               hold_vq <= 1'b0;
            end else if (!lone) begin
               hold_q  <= in_data;
               hold_vq <= 1'b1;
            end
         end
      end
   end

   assign hold_v      = hold_vq;
   assign out_busy    = out_vq;
   assign bus_valid   = out_vq;
   assign bus_data    = out_dq;
   assign bus_lane_en = out_eq;

   // R9
   word_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_data) && $stable(bus_lane_en)));

   // R2
   low_lane_chk: assert property (@(posedge clk) disable iff (rst)
      bus_valid |-> bus_lane_en[0]);

   // R4
   lone_zero_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_valid && !bus_lane_en[1]) |-> (bus_data[WORD_W-1:BYTE_W] == '0));
endmodule

// File: rtl/odd_byte_packer.sv
module odd_byte_packer
   import wbp_pkg::*;
#(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned CNT_W  = 16
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    cmd_valid,
   output logic                    cmd_ready,
   input  logic [CNT_W-1:0]        cmd_count,
   input  logic                    cmd_chain,
   input  logic                    in_valid,
   output logic                    in_ready,
   input  logic [BYTE_W-1:0]       in_data,
   output logic                    bus_valid,
   input  logic                    bus_ready,
   output logic [2*BYTE_W-1:0]     bus_data,
   output logic [1:0]              bus_lane_en,
   output logic                    done,
   output logic [CNT_W:0]          done_sent,
   output logic                    done_resid
);
   generate
      if (BYTE_W < 1) begin : g_bad_byte
         $error("odd_byte_packer: BYTE_W must be at least 1");
      end
      if (LANES != 2) begin : g_bad_lanes
         $error("odd_byte_packer: exactly two lanes are supported");
      end
   endgenerate

   logic       take;
   logic       last;
   logic       chain;
   logic       out_busy;
   logic       hold_v;
   logic [1:0] sent_inc;

   wbp_ctrl #(.CNT_W(CNT_W)) u_ctrl (
      .clk        (clk),
      .rst        (rst),
      .cmd_valid  (cmd_valid),
      .cmd_count  (cmd_count),
      .cmd_chain  (cmd_chain),
      .cmd_ready  (cmd_ready),
      .in_valid   (in_valid),
      .in_ready   (in_ready),
      .take       (take),
      .last       (last),
      .chain      (chain),
      .out_busy   (out_busy),
      .hold_v     (hold_v),
      .sent_inc   (sent_inc),
      .done       (done),
      .done_sent  (done_sent),
      .done_resid (done_resid)
   );

   wbp_pack #(.BYTE_W(BYTE_W)) u_pack (
      .clk         (clk),
      .rst         (rst),
      .take        (take),
      .last        (last),
      .chain       (chain),
      .in_data     (in_data),
      .bus_ready   (bus_ready),
      .hold_v      (hold_v),
      .out_busy    (out_busy),
      .sent_inc    (sent_inc),
      .bus_valid   (bus_valid),
      .bus_data    (bus_data),
      .bus_lane_en (bus_lane_en)
   );

   // R9
   no_take_while_full_chk: assert property (@(posedge clk) disable iff (rst)
      bus_valid |-> !in_ready);

   // R10
   plain_end_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (done && !chain && (done_sent != '0)) |-> !done_resid);
endmodule

// File: tb/odd_byte_packer_tb.sv
module odd_byte_packer_tb;
   localparam int BW = 8;
   localparam int CW = 4;

   logic          clk = 1'b0;
   logic          rst;
   logic          cmd_valid;
   logic          cmd_ready;
   logic [CW-1:0] cmd_count;
   logic          cmd_chain;
   logic          in_valid;
   logic          in_ready;
   logic [BW-1:0] in_data;
   logic          bus_valid;
   logic          bus_ready;
   logic [2*BW-1:0] bus_data;
   logic [1:0]    bus_lane_en;
   logic          done;
   logic [CW:0]   done_sent;
   logic          done_resid;

   always #5 clk = ~clk;

   odd_byte_packer #(.BYTE_W(BW), .CNT_W(CW)) u_dut (
      .clk(clk), .rst(rst),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_count(cmd_count), .cmd_chain(cmd_chain),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
      .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_data(bus_data), .bus_lane_en(bus_lane_en),
      .done(done), .done_sent(done_sent), .done_resid(done_resid)
   );

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit m_hv   = 1'b0;
   logic [7:0] m_hb = '0;

   logic [7:0]  bytes [16];
   logic [15:0] exp_d [17];
   logic [1:0]  exp_e [17];
   int          nexp;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h (cycle %0d)", rq, act, exp, cyc);
      end
   endtask

   task automatic run_xfer(input int cnt, input bit ch, input int pat, input logic [7:0] seed);
      int idx = 0;
      int widx = 0;
      bit hs = m_hv;
      bit hv = m_hv;
      logic [7:0] hb = m_hb;
      bit he;
      bit seen = 0;
      bit busy_chk = 0;
      bit stall_v = 0;
      logic [15:0] stall_d = '0;
      logic [1:0]  stall_e = '0;
      bit rdy;
      string wr;
      nexp = 0;
      for (int i = 0; i < cnt; i++) begin
         bytes[i] = seed + 8'(i);
         if (hv) begin
            exp_d[nexp] = {bytes[i], hb}; exp_e[nexp] = 2'b11; nexp++; hv = 0;
         end else if (i == cnt - 1 && !ch) begin
            exp_d[nexp] = {8'h00, bytes[i]}; exp_e[nexp] = 2'b01; nexp++;
         end else begin
            hb = bytes[i]; hv = 1;
         end
      end
      he = hv;
      chk(cmd_ready == 1'b1, "R11", int'(cmd_ready), 1);
      cmd_valid = 1'b1; cmd_count = CW'(cnt); cmd_chain = ch;
      @(negedge clk);
      cmd_valid = 1'b0;
      while (!seen) begin
         if (stall_v) begin
            chk(bus_valid && bus_data == stall_d && bus_lane_en == stall_e, "R9",
                int'(bus_data), int'(stall_d));
            stall_v = 0;
         end
         if (done) begin
            seen = 1;
            in_valid = 1'b0; bus_ready = 1'b0;
            chk(idx == cnt, "R6", idx, cnt);
            chk(widx == nexp, ch ? "R3" : "R4", widx, nexp);
            chk(int'(done_sent) == cnt + int'(hs) - int'(he), "R6", int'(done_sent), cnt + int'(hs) - int'(he));
            chk(done_resid == he, "R7", int'(done_resid), int'(he));
            if (cnt == 0) chk(done_resid == hs, "R8", int'(done_resid), int'(hs));
            else if (!ch) chk(done_resid == 1'b0, "R10", int'(done_resid), 0);
            else if ((cnt + int'(hs)) % 2 == 1) chk(done_resid == 1'b1, "R3", int'(done_resid), 1);
         end else begin
            if (!busy_chk) begin
               chk(cmd_ready == 1'b0, "R11", int'(cmd_ready), 0);
               busy_chk = 1;
            end
            if (bus_valid) chk(in_ready == 1'b0, "R9", int'(in_ready), 0);
            in_valid = (idx < cnt);
            in_data  = (idx < cnt) ? bytes[idx] : 8'h00;
            if (in_valid && in_ready) idx++;
            case (pat)
               0:       rdy = 1'b1;
               1:       rdy = cyc[0];
               default: rdy = (cyc % 3 == 0);
            endcase
            bus_ready = rdy;
            if (bus_valid) begin
               if (widx >= nexp) begin
                  chk(1'b0, ch ? "R3" : "R4", widx, nexp);
               end else if (rdy) begin
                  if (exp_e[widx] == 2'b01) wr = "R4";
                  else if (widx == 0 && hs) wr = "R5";
                  else wr = "R2";
                  chk(bus_data == exp_d[widx] && bus_lane_en == exp_e[widx], wr,
                      int'({bus_lane_en, bus_data}), int'({exp_e[widx], exp_d[widx]}));
                  widx++;
               end else begin
                  stall_v = 1; stall_d = bus_data; stall_e = bus_lane_en;
               end
            end
         end
         @(negedge clk);
      end
      chk(done == 1'b0, "R6", int'(done), 0);
      m_hv = he; m_hb = hb;
   endtask

   task automatic set_resid(input bit want);
      if (m_hv != want) begin
         if (want) run_xfer(1, 1'b1, 0, 8'hE0);
         else      run_xfer(1, 1'b0, 0, 8'hF0);
      end
   endtask

   task automatic finish_run();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      rst = 1'b1; cmd_valid = 1'b0; cmd_count = '0; cmd_chain = 1'b0;
      in_valid = 1'b0; in_data = '0; bus_ready = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R1 reset state
      chk(cmd_ready == 1'b1, "R1", int'(cmd_ready), 1);
      chk(bus_valid == 1'b0, "R1", int'(bus_valid), 0);
      chk(done == 1'b0, "R1", int'(done), 0);
      chk(done_resid == 1'b0, "R1", int'(done_resid), 0);

      // R1: reset while a residue is held discards it
      run_xfer(3, 1'b1, 0, 8'h30);
      chk(done_resid == 1'b1, "R3", int'(done_resid), 1);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      m_hv = 1'b0;
      @(negedge clk);
      chk(done_resid == 1'b0, "R1", int'(done_resid), 0);
      run_xfer(1, 1'b0, 0, 8'h5A);

      for (int pat = 0; pat < 3; pat++) begin
         for (int hs = 0; hs < 2; hs++) begin
            for (int ch = 0; ch < 2; ch++) begin
               for (int c = 0; c < 9; c++) begin
                  int cnt = (c == 8) ? 15 : c;
                  set_resid(hs[0]);
                  run_xfer(cnt, ch[0], pat, 8'(8'h11 * (c + 1) + 8'(pat * 64 + hs * 32 + ch * 16)));
               end
            end
         end
      end
      finish_run();
   end
endmodule